// File: doc/BRIEF.md
# Branch record type classifier and compactor

This block receives a list of recorded control-flow transfers, one record per cycle. Each record carries a source address, a target address, the first two opcode bytes found at the source, the ModRM byte, a flag saying the relative immediate is zero, an abort flag and an in-transaction flag. The block turns each record into a branch-type word. The word has exactly one class bit, or none. A privilege bit for the target is then ORed in. When the request asks for it, a transaction bit is ORed in as well.

The type word is then compared with the requested filter word. Records whose type is not fully covered by the request are dropped. The survivors receive consecutive write indices starting at zero, so a consumer can store them densely while keeping their original order. The block accepts one record per cycle, and results appear one cycle later. When the list ends, the number of surviving records is reported. Any address at or above `KERNEL_BASE` counts as privileged.

Top module: `branch_sieve`

## Requirements
- R1: After reset, `out_valid` and `done` are low and `count` is zero.
- R2: If the source or target address is zero, the type is none (all zero). No decode takes place.
- R3: If the abort flag is set on a record with nonzero addresses, the type is abort (bit 12) ORed with the target privilege bit, and the opcode bytes are ignored.
- R4: When the first byte is 0x0F, the second byte decodes as follows:
  - 0x05 and 0x34 give syscall (bit 4).
  - 0x07 and 0x35 give sysret (bit 5).
  - 0x80 to 0x8F give conditional (bit 8).
  - Any other value gives none.
- R5: Single-byte opcodes decode as follows:
  - 0x70 to 0x7F and 0xE0 to 0xE3 give conditional (bit 8).
  - 0xC2, 0xC3, 0xCA and 0xCB give return (bit 3).
  - 0xCF gives interrupt return (bit 7).
  - 0xCC to 0xCE give software interrupt (bit 6).
  - 0xE9 to 0xEB give jump (bit 9).
  - 0x9A gives call (bit 2).
  - 0xE8 gives call (bit 2), or zero-length call (bit 15) when the immediate-zero flag is set.
  - Anything else gives none.
- R6: For opcode 0xFF, ModRM bits 5:3 decode as follows:
  - 2 or 3 gives indirect call (bit 11).
  - 4 or 5 gives indirect jump (bit 17).
  - Any other value gives none.
- R7: A record that goes from a user source to a kernel target becomes hardware interrupt/trap (bit 10), whatever it decoded to, unless it decoded as syscall or software interrupt. The target privilege is then ORed in: user is bit 0, kernel is bit 1. An address at or above `KERNEL_BASE` is kernel.
- R8: If the filter has bit 13 or bit 14 set, each non-none type also gains one transaction bit. It gains bit 13 when the in-transaction flag is set, and bit 14 when the flag is clear.
- R9: A record is kept only when its type is non-none and every bit of the type is also set in the filter.
- R10: If the filter holds every bit of mask 0x29FFF, every record is kept, including records of type none. This mask covers both privilege bits and all branch classes.
- R11: A kept record shows `out_valid` one cycle after it is presented. Its `out_idx` equals the number of records kept earlier in the same list. A record presented with `in_first` starts a new list at index 0.
- R12: One cycle after a record presented with `in_last`, `done` pulses high for one cycle, and `count` then holds the number of records kept in that list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_mask | input | 18 | Requested type mask |
| in_valid | input | 1 | Record present this cycle |
| in_first | input | 1 | Record opens a new list |
| in_last | input | 1 | Record closes the list |
| in_src | input | AW | Source address |
| in_dst | input | AW | Target address |
| in_op0 | input | 8 | First opcode byte |
| in_op1 | input | 8 | Second opcode byte |
| in_modrm | input | 8 | ModRM byte |
| in_imm_zero | input | 1 | Relative immediate is zero |
| in_abort | input | 1 | Record is a transaction abort |
| in_intx | input | 1 | Record was inside a transaction |
| out_valid | output | 1 | Kept record present |
| out_idx | output | IW | Dense write index of the kept record |
| out_src | output | AW | Source address of the last record |
| out_dst | output | AW | Target address of the last record |
| out_type | output | 18 | Type word of the last record |
| done | output | 1 | List finished |
| count | output | IW | Records kept in the finished list |

## Verification
The hardest case to reach is the interaction between the privilege override and the filter. In this case a record that decodes as none, or as a conditional, is turned into a kept interrupt only because it crosses from user to kernel. A type-none record can only survive under the full bypass mask. The stimulus table mixes crossing and non-crossing records, zero addresses and an abort inside one long list, and changes the filter per record, so kept and dropped records interleave and the dense index is exercised between drops. A second short list then checks that the index restarts at zero.

// File: rtl/branch_sieve.sv
module branch_sieve #(
  parameter int AW = 32,
  parameter logic [AW-1:0] KERNEL_BASE = 32'h8000_0000,
  parameter int MAX_RECS = 64,
  localparam int IW = $clog2(MAX_RECS + 1),
  localparam int TW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] filt_mask,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [AW-1:0] in_src,
  input  logic [AW-1:0] in_dst,
  input  logic [7:0]    in_op0,
  input  logic [7:0]    in_op1,
  input  logic [7:0]    in_modrm,
  input  logic          in_imm_zero,
  input  logic          in_abort,
  input  logic          in_intx,
  output logic          out_valid,
  output logic [IW-1:0] out_idx,
  output logic [AW-1:0] out_src,
  output logic [AW-1:0] out_dst,
  output logic [TW-1:0] out_type,
  output logic          done,
  output logic [IW-1:0] count
);

  localparam logic [TW-1:0] T_USR   = TW'(1) << 0;
  localparam logic [TW-1:0] T_KRN   = TW'(1) << 1;
  localparam logic [TW-1:0] T_CALL  = TW'(1) << 2;
  localparam logic [TW-1:0] T_RET   = TW'(1) << 3;
  localparam logic [TW-1:0] T_SYSC  = TW'(1) << 4;
  localparam logic [TW-1:0] T_SYSR  = TW'(1) << 5;
  localparam logic [TW-1:0] T_SWI   = TW'(1) << 6;
  localparam logic [TW-1:0] T_IRET  = TW'(1) << 7;
  localparam logic [TW-1:0] T_COND  = TW'(1) << 8;
  localparam logic [TW-1:0] T_JMP   = TW'(1) << 9;
  localparam logic [TW-1:0] T_IRQ   = TW'(1) << 10;
  localparam logic [TW-1:0] T_ICALL = TW'(1) << 11;
  localparam logic [TW-1:0] T_ABORT = TW'(1) << 12;
  localparam logic [TW-1:0] T_INTX  = TW'(1) << 13;
  localparam logic [TW-1:0] T_NOTX  = TW'(1) << 14;
  localparam logic [TW-1:0] T_ZCALL = TW'(1) << 15;
  localparam logic [TW-1:0] T_IJMP  = TW'(1) << 17;
  localparam logic [TW-1:0] T_PLM   = T_USR | T_KRN;
  localparam logic [TW-1:0] T_CLASS = T_CALL | T_RET | T_SYSC | T_SYSR | T_SWI | T_IRET |
                                      T_COND | T_JMP | T_IRQ | T_ICALL | T_ABORT |
                                      T_ZCALL | T_IJMP;
  localparam logic [TW-1:0] T_ALL   = T_PLM | T_CLASS;

  logic          src_k, dst_k;
  logic [TW-1:0] cls, ty;
  logic          bypass, keep;
  logic [IW-1:0] wr_ptr, base;

  assign src_k = in_src >= KERNEL_BASE;
  assign dst_k = in_dst >= KERNEL_BASE;

  always_comb begin
    cls = '0;
    case (in_op0) inside
      8'h0F:
        case (in_op1) inside
          8'h05, 8'h34:   cls = T_SYSC;
          8'h07, 8'h35:   cls = T_SYSR;
          [8'h80:8'h8F]:  cls = T_COND;
          default:        cls = '0;
        endcase
      [8'h70:8'h7F], [8'hE0:8'hE3]: cls = T_COND;
      8'hC2, 8'hC3, 8'hCA, 8'hCB:   cls = T_RET;
      8'hCF:                        cls = T_IRET;
      [8'hCC:8'hCE]:                cls = T_SWI;
      8'hE8:                        cls = in_imm_zero ? T_ZCALL : T_CALL;
      8'h9A:                        cls = T_CALL;
      [8'hE9:8'hEB]:                cls = T_JMP;
      8'hFF:
        case (in_modrm[5:3])
          3'd2, 3'd3: cls = T_ICALL;
          3'd4, 3'd5: cls = T_IJMP;
          default:    cls = '0;
        endcase
      default: cls = '0;
    endcase
  end

  always_comb begin
    ty = '0;
    if (in_src != '0 && in_dst != '0) begin
      if (in_abort)
        ty = T_ABORT;
      else if (!src_k && dst_k && cls != T_SYSC && cls != T_SWI)
        ty = T_IRQ;
      else
        ty = cls;
      if (ty != '0) begin
        ty = ty | (dst_k ? T_KRN : T_USR);
        if (filt_mask[13] || filt_mask[14])
          ty = ty | (in_intx ? T_INTX : T_NOTX);
      end
    end
  end

  assign bypass = (filt_mask & T_ALL) == T_ALL;
  assign keep   = bypass || (ty != '0 && (filt_mask & ty) == ty);
  assign base   = in_first ? '0 : wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      out_idx   <= '0;
      out_src   <= '0;
      out_dst   <= '0;
      out_type  <= '0;
      wr_ptr    <= '0;
      count     <= '0;
    end else begin
      out_valid <= in_valid && keep;
      done      <= in_valid && in_last;
      if (in_valid) begin
        out_idx  <= base;
        out_src  <= in_src;
        out_dst  <= in_dst;
        out_type <= ty;
        wr_ptr   <= base + IW'(keep);
        if (in_last)
          count <= base + IW'(keep);
      end
    end
  end

  // R9 / R10: a surviving record is covered by the request or the request is full
  assert_kept_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((($past(filt_mask) & out_type) == out_type && out_type != '0) ||
                   (($past(filt_mask) & T_ALL) == T_ALL)));

  // R10: a type-none record only survives under the full request
  assert_none_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type == '0) |-> (($past(filt_mask) & T_ALL) == T_ALL));

  // R5: at most one class bit in any type word
  assert_one_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_type & T_CLASS));

  // R7: a non-none type has exactly one privilege bit
  assert_one_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_type != '0) |-> ($countones(out_type & T_PLM) == 1));

  // R12: done follows a closing record
  assert_done_follows_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last));

  // R11: a kept record in the middle of a list advances by one from the previous kept record
  assert_dense_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first && keep) |=> (out_idx == $past(wr_ptr)));

endmodule

// File: tb/test_branch_sieve.sv
module test_branch_sieve;
  localparam int AW = 32;
  localparam int IW = 7;
  localparam int NV = 23;
  localparam logic [31:0] U = 32'h0000_1000;
  localparam logic [31:0] K = 32'h8000_1000;
  localparam logic [17:0] FULL = 18'h29FFF;

  logic clk = 0, rst_n = 0;
  logic [17:0] filt_mask = '0;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [AW-1:0] in_src = '0, in_dst = '0;
  logic [7:0] in_op0 = '0, in_op1 = '0, in_modrm = '0;
  logic in_imm_zero = 0, in_abort = 0, in_intx = 0;
  logic out_valid, done;
  logic [IW-1:0] out_idx, count;
  logic [AW-1:0] out_src, out_dst;
  logic [17:0] out_type;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  branch_sieve i_branch_sieve (
    .clk, .rst_n, .filt_mask, .in_valid, .in_first, .in_last, .in_src, .in_dst,
    .in_op0, .in_op1, .in_modrm, .in_imm_zero, .in_abort, .in_intx,
    .out_valid, .out_idx, .out_src, .out_dst, .out_type, .done, .count);

  // {src, dst, op0, op1, modrm, imm_zero, abort, intx, filter, expected type, expected keep}
  localparam logic [127:0] VEC [NV] = '{
    {U, U, 8'h74, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00101, 18'h00101, 1'b1}, // R5 cond
    {U, U, 8'hE8, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00101, 18'h00005, 1'b0}, // R5 call, R9 drop
    {U, U, 8'hE8, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 18'h08001, 18'h08001, 1'b1}, // R5 zero call
    {U, K, 8'h0F, 8'h05, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00012, 18'h00012, 1'b1}, // R4 syscall
    {U, K, 8'h74, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00402, 18'h00402, 1'b1}, // R7 irq
    {K, U, 8'hCF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00083, 18'h00081, 1'b1}, // R5 iret
    {U, U, 8'hFF, 8'h00, 8'h10, 1'b0, 1'b0, 1'b0, 18'h00003, 18'h00801, 1'b0}, // R6 ind call
    {U, U, 8'hFF, 8'h00, 8'h20, 1'b0, 1'b0, 1'b0, 18'h20001, 18'h20001, 1'b1}, // R6 ind jmp
    {U, U, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, FULL,      18'h00000, 1'b1}, // R10 bypass
    {U, U, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h29FFD, 18'h00000, 1'b0}, // R10 partial
    {32'h0, U, 8'h74, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00101, 18'h00000, 1'b0}, // R2
    {U, K, 8'h74, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 18'h01002, 18'h01002, 1'b1}, // R3 abort
    {U, U, 8'hC3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 18'h02009, 18'h02009, 1'b1}, // R8 in tx
    {U, U, 8'hC3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h02009, 18'h04009, 1'b0}, // R8 no tx
    {K, K, 8'h0F, 8'h85, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00102, 18'h00102, 1'b1}, // R4 cond
    {K, U, 8'h0F, 8'h07, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00021, 18'h00021, 1'b1}, // R4 sysret
    {U, K, 8'hCD, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00042, 18'h00042, 1'b1}, // R7 swi kept
    {U, U, 8'hEB, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00201, 18'h00201, 1'b1}, // R5 jmp
    {K, K, 8'h9A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00006, 18'h00006, 1'b1}, // R5 far call
    {U, U, 8'h90, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00003, 18'h00000, 1'b0}, // R5 none
    {U, U, 8'h0F, 8'h34, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00011, 18'h00011, 1'b1}, // R4 sysenter
    {K, K, 8'hE2, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00103, 18'h00102, 1'b1}, // R5 loop
    {U, K, 8'h90, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00402, 18'h00402, 1'b1}  // R7 none->irq
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] v, input logic first, input logic last);
    in_valid = 1; in_first = first; in_last = last;
    {in_src, in_dst, in_op0, in_op1, in_modrm, in_imm_zero, in_abort, in_intx, filt_mask} = v[127:19];
  endtask

  int exp_idx = 0;

  task automatic check_vec(input int i);
    logic [17:0] et;
    logic ek;
    et = VEC[i][18:1];
    ek = VEC[i][0];
    check($sformatf("R9 keep vec %0d", i), 32'(out_valid), 32'(ek));
    check($sformatf("R2-decode type vec %0d", i), 32'(out_type), 32'(et));
    if (ek) begin
      check($sformatf("R11 idx vec %0d", i), 32'(out_idx), 32'(exp_idx));
      exp_idx++;
    end
    check($sformatf("R12 done vec %0d", i), 32'(done), 32'(i == NV - 1));
  endtask

  initial begin
    fork
      begin
        #1;
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 done", 32'(done), 0);
        check("R1 count", 32'(count), 0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < NV; i++) begin
          @(negedge clk);
          if (i > 0) check_vec(i - 1);
          drive(VEC[i], i == 0, i == NV - 1);
        end
        @(negedge clk);
        check_vec(NV - 1);
        check("R12 count", 32'(count), 32'(exp_idx));
        in_valid = 0; in_last = 0;
        @(negedge clk);
        check("R12 done one cycle", 32'(done), 0);
        check("R11 idle no output", 32'(out_valid), 0);
        // R11 new list restarts at zero
        drive({U, U, 8'hC2, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 18'h00009, 18'h0, 1'b0}, 1, 1);
        @(negedge clk);
        check("R11 restart idx", 32'(out_idx), 0);
        check("R11 restart valid", 32'(out_valid), 1);
        check("R5 ret type", 32'(out_type), 32'h9);
        check("R12 restart count", 32'(count), 1);
        in_valid = 0;
        @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule